// File: doc/BRIEF.md
# Two-Wire Slave Start Detector with Clock Hold

This block is the slave-side front end of a small two-wire serial port. It samples the open-drain SDA and SCL pins through a synchronizer and recognizes start conditions (SDA falling while SCL is high) and stop conditions (SDA rising while SCL is high). A start sets a sticky flag, which can raise an interrupt. When the master then pulls SCL low for the first time, the block keeps SCL pulled low. The hold lasts until software clears the flag. A sleeping controller therefore has time to wake up and prepare before the address byte is clocked in.

An 8-bit data register samples SDA on each rising SCL edge and shifts the sampled bit in on the following falling edge, MSB first. Its top bit drives SDA low through an open-drain output when the SDA direction bit is set. A 4-bit counter counts SCL edges and sets an overflow flag after 16 edges, which is one byte. The overflow also holds SCL low, so software can prepare the acknowledge. A stop sets its own flag and releases any hold.

Top module: `twi_start_hold`

## Requirements
- R1: After reset all flags are 0, the counter is 0, the data register is 0, and both pin pull-downs (`sda_low_o`, `scl_low_o`) are inactive.
- R2: SDA falling while SCL stays high sets `start_flag`. The flag stays set until `clr_start` is pulsed. SDA changing while SCL is low never sets it.
- R3: `start_irq` is 1 exactly when `start_flag` is set and `start_irq_en` is 1.
- R4: When `start_flag` is set and SCL falls, `scl_low_o` goes to 1 and stays at 1 until `start_flag` is cleared.
- R5: The data register captures SDA on every rising SCL edge and shifts that bit into bit 0 on the next falling edge. After eight SCL clocks, `data_o` equals the eight SDA bits, with the first bit in bit 7.
- R6: The counter increments by one on every SCL edge, rising or falling, and `cnt_rst` forces it to 0. On the 16th edge it wraps from 15 to 0 and sets `ovf_flag`.
- R7: An overflow holds `scl_low_o` at 1 until `clr_ovf` is pulsed. `ovf_flag` stays set until that pulse.
- R8: `sda_low_o` is 1 exactly when `sda_dir` is 1 and bit 7 of the data register is 0. With `sda_dir` at 0, SDA is released.
- R9: SDA rising while SCL is high sets `stop_flag` (cleared by `clr_stop` or by the next start) and releases any SCL hold. While `stop_flag` is set, a falling SCL edge does not start a new hold.
- R10: A pulse on `wr_en` loads `wr_data` into the data register on that clock edge, taking precedence over a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_i | input | 1 | SDA pin sample |
| scl_i | input | 1 | SCL pin sample |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 8 | Data register write value |
| cnt_rst | input | 1 | Edge counter reset strobe |
| clr_start | input | 1 | Start flag clear strobe |
| clr_stop | input | 1 | Stop flag clear strobe |
| clr_ovf | input | 1 | Overflow flag clear strobe |
| sda_dir | input | 1 | Enables the SDA pull-down driver |
| start_irq_en | input | 1 | Start interrupt enable |
| sda_low_o | output | 1 | Pulls SDA low when 1 |
| scl_low_o | output | 1 | Pulls SCL low (clock hold) when 1 |
| start_flag | output | 1 | Sticky start-detected flag |
| stop_flag | output | 1 | Sticky stop-detected flag |
| ovf_flag | output | 1 | Sticky counter overflow flag |
| start_irq | output | 1 | Start interrupt request |
| data_o | output | 8 | Data register contents |
| cnt_o | output | 4 | SCL edge counter |

## Verification
A wrong bit sampler or a wrong shift order shows up at `data_o` once the byte ends. It also shows up bit by bit on `sda_low_o`, because the bench loops the transmitted bits back through the wired line. A wrong count in the edge counter moves the overflow. The bench sees this as a clock hold that comes one or more edges early or late, or as a wrong `cnt_o` in the middle of the byte. A hold that clears wrongly either stalls the modelled master, which waits for the SCL line to rise, or lets the master run on before software has cleared the flag. Either way the failure appears within the same bit period, a few system cycles after the synchronizer delay.

// File: rtl/tws_pkg.sv
package tws_pkg;

  // Line events decoded from the synchronized pins, one cycle wide each.
  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } tws_evt_t;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2,
  parameter int N      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  // Lines idle high, so the flops reset to 1 and produce no false edge.
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '1;
      else        ff <= {ff[STAGES-2:0], d[i]};
    end
    assign q[i] = ff[STAGES-1];
  end

endmodule

// File: rtl/tws_cond.sv
module tws_cond
  import tws_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sda_s,
  input  logic     scl_s,
  output tws_evt_t evt
);

  logic sda_q;
  logic scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_s;
      scl_q <= scl_s;
    end
  end

  // SCL must be high both before and after the SDA transition.
  always_comb begin
    evt.scl_rise = scl_s & ~scl_q;
    evt.scl_fall = ~scl_s & scl_q;
    evt.start    = scl_s & scl_q & sda_q & ~sda_s;
    evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/tws_shift.sv
module tws_shift
  import tws_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tws_evt_t          evt,
  input  logic              sda_s,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cnt_rst,
  output logic [DATA_W-1:0] data,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf_pulse
);

  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [DATA_W-1:0] data_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              rx_bit;
  logic              rx_bit_d;

  always_comb begin
    data_d    = data;
    rx_bit_d  = rx_bit;
    cnt_d     = cnt;
    ovf_pulse = 1'b0;
    if (evt.scl_rise) rx_bit_d = sda_s;
    if (wr_en)             data_d = wr_data;
    else if (evt.scl_fall) data_d = {data[DATA_W-2:0], rx_bit};
    if (cnt_rst) begin
      cnt_d = '0;
    end else if (evt.scl_rise | evt.scl_fall) begin
      cnt_d     = cnt + 1'b1;
      ovf_pulse = (cnt == CNT_LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data   <= '0;
      rx_bit <= 1'b0;
      cnt    <= '0;
    end else begin
      data   <= data_d;
      rx_bit <= rx_bit_d;
      cnt    <= cnt_d;
    end
  end

endmodule

// File: rtl/twi_start_hold.sv
module twi_start_hold
  import tws_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_i,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cnt_rst,
  input  logic              clr_start,
  input  logic              clr_stop,
  input  logic              clr_ovf,
  input  logic              sda_dir,
  input  logic              start_irq_en,
  output logic              sda_low_o,
  output logic              scl_low_o,
  output logic              start_flag,
  output logic              stop_flag,
  output logic              ovf_flag,
  output logic              start_irq,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  cnt_o
);

  localparam int RST_STAGES = 2;

  // Reset asserts asynchronously and is released on a clock edge.
  logic [RST_STAGES-1:0] rst_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_q[RST_STAGES-1];

  logic [1:0] pins_s;
  tws_evt_t   evt;
  logic       ovf_pulse;

  tws_sync #(.STAGES(SYNC_STAGES), .N(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({scl_i, sda_i}),
    .q     (pins_s)
  );

  tws_cond u_cond (
    .clk   (clk),
    .rst_n (rst_int_n),
    .sda_s (pins_s[0]),
    .scl_s (pins_s[1]),
    .evt   (evt)
  );

  tws_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .evt       (evt),
    .sda_s     (pins_s[0]),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cnt_rst   (cnt_rst),
    .data      (data_o),
    .cnt       (cnt_o),
    .ovf_pulse (ovf_pulse)
  );

  logic start_d, stop_d, ovf_d;
  logic hold_start, hold_start_d;
  logic hold_ovf, hold_ovf_d;

  always_comb begin
    start_d = evt.start ? 1'b1 : (clr_start ? 1'b0 : start_flag);
    stop_d  = evt.stop  ? 1'b1 : ((evt.start | clr_stop) ? 1'b0 : stop_flag);
    ovf_d   = ovf_pulse ? 1'b1 : (clr_ovf ? 1'b0 : ovf_flag);

    hold_start_d = hold_start;
    if (!start_d || evt.stop)
      hold_start_d = 1'b0;
    else if (start_flag && !stop_flag && evt.scl_fall)
      hold_start_d = 1'b1;

    hold_ovf_d = hold_ovf;
    if (!ovf_d || evt.stop) hold_ovf_d = 1'b0;
    else if (ovf_pulse)     hold_ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      start_flag <= 1'b0;
      stop_flag  <= 1'b0;
      ovf_flag   <= 1'b0;
      hold_start <= 1'b0;
      hold_ovf   <= 1'b0;
    end else begin
      start_flag <= start_d;
      stop_flag  <= stop_d;
      ovf_flag   <= ovf_d;
      hold_start <= hold_start_d;
      hold_ovf   <= hold_ovf_d;
    end
  end

  assign scl_low_o = hold_start | hold_ovf;
  assign sda_low_o = sda_dir & ~data_o[DATA_W-1];
  assign start_irq = start_flag & start_irq_en;

endmodule

// File: rtl/tws_checker.sv
module tws_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              cnt_rst,
  input logic              clr_start,
  input logic              clr_ovf,
  input logic              sda_dir,
  input logic              start_irq_en,
  input logic              sda_low_o,
  input logic              scl_low_o,
  input logic              start_flag,
  input logic              stop_flag,
  input logic              ovf_flag,
  input logic              start_irq,
  input logic [DATA_W-1:0] data_o,
  input logic [CNT_W-1:0]  cnt_o
);

  a_r2_start_sticky: assert property (@(posedge clk) disable iff (!rst_ok)
    (start_flag && !clr_start) |=> start_flag);

  a_r3_irq_gated: assert property (@(posedge clk) disable iff (!rst_ok)
    start_irq |-> (start_flag && start_irq_en));

  a_r4_hold_has_cause: assert property (@(posedge clk) disable iff (!rst_ok)
    scl_low_o |-> (start_flag || ovf_flag));

  a_r6_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_ok)
    cnt_rst |=> (cnt_o == '0));

  a_r6_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(ovf_flag) |-> (cnt_o == '0));

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_ok)
    (ovf_flag && !clr_ovf) |=> ovf_flag);

  a_r8_sda_released: assert property (@(posedge clk) disable iff (!rst_ok)
    !sda_dir |-> !sda_low_o);

  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(stop_flag) |-> !scl_low_o);

  a_r10_cpu_load: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_en |=> (data_o == $past(wr_data)));

endmodule

bind twi_start_hold tws_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_ok       (rst_int_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .cnt_rst      (cnt_rst),
  .clr_start    (clr_start),
  .clr_ovf      (clr_ovf),
  .sda_dir      (sda_dir),
  .start_irq_en (start_irq_en),
  .sda_low_o    (sda_low_o),
  .scl_low_o    (scl_low_o),
  .start_flag   (start_flag),
  .stop_flag    (stop_flag),
  .ovf_flag     (ovf_flag),
  .start_irq    (start_irq),
  .data_o       (data_o),
  .cnt_o        (cnt_o)
);

// File: tb/twi_start_hold_test.sv
module twi_start_hold_test;

  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       msda = 1'b1;
  logic       mscl = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cnt_rst = 1'b0, clr_start = 1'b0, clr_stop = 1'b0, clr_ovf = 1'b0;
  logic       sda_dir = 1'b0, start_irq_en = 1'b0;
  logic       sda_low_o, scl_low_o, start_flag, stop_flag, ovf_flag, start_irq;
  logic [7:0] data_o;
  logic [3:0] cnt_o;
  logic       sda_line, scl_line;

  int nchecks = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // Wired-AND open-drain lines with external pull-ups.
  assign sda_line = msda & ~sda_low_o;
  assign scl_line = mscl & ~scl_low_o;

  twi_start_hold uut (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_line), .scl_i(scl_line),
    .wr_en(wr_en), .wr_data(wr_data), .cnt_rst(cnt_rst),
    .clr_start(clr_start), .clr_stop(clr_stop), .clr_ovf(clr_ovf),
    .sda_dir(sda_dir), .start_irq_en(start_irq_en),
    .sda_low_o(sda_low_o), .scl_low_o(scl_low_o), .start_flag(start_flag),
    .stop_flag(stop_flag), .ovf_flag(ovf_flag), .start_irq(start_irq),
    .data_o(data_o), .cnt_o(cnt_o)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    nchecks++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(bit b);
    msda = b;
    tick(H);
    mscl = 1'b1;
    tick(1);
    while (!scl_line) tick(1);
    tick(H);
    mscl = 1'b0;
    tick(H);
  endtask

  task automatic gen_start();
    msda = 1'b1; mscl = 1'b1; tick(H);
    msda = 1'b0; tick(H);
  endtask

  task automatic gen_stop();
    msda = 1'b0; tick(H);
    mscl = 1'b1; tick(H);
    msda = 1'b1; tick(H);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    chk("R1 start_flag", start_flag, 0);
    chk("R1 stop_flag", stop_flag, 0);
    chk("R1 ovf_flag", ovf_flag, 0);
    chk("R1 cnt", cnt_o, 0);
    chk("R1 data", data_o, 0);
    chk("R1 scl_low", scl_low_o, 0);
    chk("R1 sda_low", sda_low_o, 0);

    // Receive sweep over every byte value.
    for (int v = 0; v < 256; v++) begin
      start_irq_en = v[0];
      gen_start();
      chk("R2 start set", start_flag, 1);
      chk("R3 irq", start_irq, v[0]);
      mscl = 1'b0; tick(H);
      chk("R4 hold after fall", scl_low_o, 1);
      mscl = 1'b1; tick(H);
      chk("R4 hold while flag set", scl_line, 0);
      mscl = 1'b0;
      clr_start = 1'b1; cnt_rst = 1'b1; tick(1);
      clr_start = 1'b0; cnt_rst = 1'b0; tick(H);
      chk("R4 released on clear", scl_low_o, 0);
      chk("R6 cnt reset", cnt_o, 0);
      chk("R3 irq gone", start_irq, 0);
      for (int i = 7; i >= 0; i--) begin
        send_bit(v[i]);
        if (i == 5) chk("R6 mid-byte count", cnt_o, 6);
      end
      chk("R5 received byte", data_o, v);
      chk("R6 overflow", ovf_flag, 1);
      chk("R6 wrap", cnt_o, 0);
      chk("R7 hold on overflow", scl_low_o, 1);
      chk("R2 no start during data", start_flag, 0);
      clr_ovf = 1'b1; tick(1); clr_ovf = 1'b0; tick(H);
      chk("R7 released on clear", scl_low_o, 0);
      chk("R7 flag cleared", ovf_flag, 0);
      send_bit(1'b0);
      gen_stop();
      chk("R9 stop flag", stop_flag, 1);
      clr_stop = 1'b1; tick(1); clr_stop = 1'b0; tick(2);
    end

    // R9: stop right after start disarms the hold.
    gen_start();
    msda = 1'b1; tick(H);
    chk("R9 stop seen", stop_flag, 1);
    chk("R9 start still set", start_flag, 1);
    mscl = 1'b0; tick(H);
    chk("R9 no hold after stop", scl_low_o, 0);
    clr_start = 1'b1; clr_stop = 1'b1; tick(1);
    clr_start = 1'b0; clr_stop = 1'b0; tick(H);

    // R10 / R8 transmit with loopback on the wired line.
    sda_dir = 1'b1;
    for (int k = 0; k < 16; k++) begin
      automatic logic [7:0] v = 8'((k * 8'd37) ^ (k << 4));
      wr_data = v; wr_en = 1'b1; cnt_rst = 1'b1; tick(1);
      wr_en = 1'b0; cnt_rst = 1'b0;
      chk("R10 cpu load", data_o, v);
      tick(H);
      for (int i = 7; i >= 0; i--) begin
        chk("R8 sda drive", sda_low_o, !v[i]);
        mscl = 1'b1; tick(H);
        mscl = 1'b0; tick(H);
      end
      chk("R5 loopback byte", data_o, v);
      chk("R7 hold on tx overflow", scl_low_o, 1);
      clr_ovf = 1'b1; tick(1); clr_ovf = 1'b0; tick(H);
    end
    wr_data = 8'h00; wr_en = 1'b1; tick(1); wr_en = 1'b0; tick(1);
    chk("R8 driven low", sda_low_o, 1);
    sda_dir = 1'b0; tick(1);
    chk("R8 released", sda_low_o, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule